// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit linear address into a 32-bit physical address by reading two levels of translation tables from memory. A caller presents the linear address together with the current directory base value over a valid/ready handshake. The walker then makes two reads over a simple memory port. The first read fetches the directory entry. The second fetches the page table entry that the directory entry points to. When the walk ends, the walker reports the translated address, or a fault if an entry at either level is marked not present.

The linear address is divided from the top down. A 10-bit directory index occupies bits 31:22, a 10-bit table index occupies bits 21:12, and a 12-bit page offset occupies bits 11:0. Every entry is one 32-bit word. Its upper 20 bits name a 4096-byte-aligned frame, and its lower 12 bits hold flags. Each table has 1024 entries, so an entry's byte address is the table's frame base plus four times the index.

The walker handles one translation at a time. It holds `req_ready` low from the moment it accepts a request until the cycle after its done pulse. While `req_ready` is low, the caller must keep its request waiting, and the walker ignores both `req_valid` and the request fields. The memory port has no back-pressure. Each read is a single-cycle request pulse, and the memory must answer with one response at least one cycle later.

Top module: `pt_walker`

## Requirements
- R1: The directory entry is read from {dir_base[31:12], 12'h000} + 4 × lin[31:22]. The low 12 bits of `dir_base` have no effect on this address.
- R2: The page table entry is read from {pde[31:12], 12'h000} + 4 × lin[21:12], where pde is the directory entry returned by the first read.
- R3: On a successful walk, `phys_addr` equals {pte[31:12], lin[11:0]} in the cycle where `done` is high, where pte is the page table entry.
- R4: Bit 0 of an entry is its present flag. If the directory entry has bit 0 clear, the walk ends with `done` and `fault` both high, and no second read is issued.
- R5: If the page table entry has bit 0 clear, the walk ends with `done` and `fault` both high.
- R6: `req_ready` is high only while the walker is idle. A request is taken on a cycle with `req_valid` and `req_ready` both high. Changes to the request fields after that cycle do not affect the result.
- R7: Each read appears as a one-cycle `mem_req_valid` pulse. The table read is issued only after the directory response has arrived. A `mem_rsp_valid` that arrives while no read is outstanding, including in the cycle of the request pulse itself, is ignored.
- R8: `done` is high for exactly one cycle per accepted request, and `fault` is never high without `done`.
- R9: A synchronous active-high `rst` abandons any walk in progress and returns the walker to idle, with `done`, `fault` and `mem_req_valid` low and `req_ready` high.
- R10: Entry bits 11:1 are flags that have no effect on any address the walker produces.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | A translation request is offered |
| req_ready | output | 1 | The walker is idle and will take a request |
| req_lin_addr | input | 32 | Linear address to translate |
| dir_base | input | 32 | Directory base register value; bits 31:12 are used |
| mem_req_valid | output | 1 | One-cycle read request pulse |
| mem_req_addr | output | 32 | Byte address of the entry to read |
| mem_rsp_valid | input | 1 | Read data is returned this cycle |
| mem_rsp_data | input | 32 | Entry word returned by memory |
| done | output | 1 | One-cycle pulse that ends a walk |
| fault | output | 1 | With `done`: a not-present entry stopped the walk |
| phys_addr | output | 32 | Translated address, valid with `done` when `fault` is low |

## Verification
The bench builds the walker with its default parameters: a 32-bit address, 10-bit indices and a 12-bit offset. At these values, the all-zero and all-ones indices reach the first and last entries of both tables. A directory base with nonzero low bits shows whether those bits leak into the entry address. The bench memory answers with latencies from one to four cycles and can inject stray responses whenever no read is outstanding. This exercises the rule that the second read waits for the first response, along with the single-pulse request protocol. Faults at each level, a request held high through a whole walk, and a reset in the middle of a walk cover the remaining control paths.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;
  typedef enum logic [1:0] {
    WS_IDLE = 2'd0,
    WS_DIR  = 2'd1,
    WS_PTE  = 2'd2,
    WS_DONE = 2'd3
  } walk_state_e;
endpackage

// File: rtl/pt_walk_ctrl.sv
module pt_walk_ctrl
  import pt_walker_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        req_valid,
  input  logic        rsp_valid,
  input  logic        rsp_present,
  output logic        req_ready,
  output logic        accept,
  output logic        take_dir,
  output logic        take_pte,
  output walk_state_e state,
  output logic        mem_req_valid,
  output logic        done,
  output logic        fault
);
  logic issued;   // the read for the current level has been sent
  logic fault_q;

  always_comb begin
    req_ready     = (state == WS_IDLE);
    accept        = req_ready && req_valid;
    take_dir      = (state == WS_DIR) && issued && rsp_valid;
    take_pte      = (state == WS_PTE) && issued && rsp_valid;
    mem_req_valid = ((state == WS_DIR) || (state == WS_PTE)) && !issued;
    done          = (state == WS_DONE);
    fault         = done && fault_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= WS_IDLE;
      issued  <= 1'b0;
      fault_q <= 1'b0;
    end else begin
      case (state)
        WS_IDLE: begin
          fault_q <= 1'b0;
          issued  <= 1'b0;
          if (req_valid) state <= WS_DIR;
        end
        WS_DIR: begin
          if (!issued) issued <= 1'b1;
          else if (rsp_valid) begin
            issued <= 1'b0;
            if (rsp_present) state <= WS_PTE;
            else begin
              fault_q <= 1'b1;
              state   <= WS_DONE;
            end
          end
        end
        WS_PTE: begin
          if (!issued) issued <= 1'b1;
          else if (rsp_valid) begin
            issued  <= 1'b0;
            fault_q <= !rsp_present;
            state   <= WS_DONE;
          end
        end
        default: state <= WS_IDLE;
      endcase
    end
  end

  p_done_single_r8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  p_fault_needs_done_r8: assert property (@(posedge clk) disable iff (rst)
    fault |-> done);
  p_req_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid |=> !mem_req_valid);
  p_dir_fault_stops_r4: assert property (@(posedge clk) disable iff (rst)
    (take_dir && !rsp_present) |=> (done && fault && !mem_req_valid));
  p_busy_after_accept_r6: assert property (@(posedge clk) disable iff (rst)
    accept |=> !req_ready);
  p_reset_idle_r9: assert property (@(posedge clk)
    rst |=> (req_ready && !done && !mem_req_valid));
endmodule

// File: rtl/pt_walk_dp.sv
module pt_walk_dp
  import pt_walker_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int IDX_W       = 10,
  parameter int OFF_W       = 12,
  parameter int ENTRY_SHIFT = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  logic              take_dir,
  input  logic              take_pte,
  input  walk_state_e       state,
  input  logic [ADDR_W-1:0] lin_in,
  input  logic [ADDR_W-1:0] base_in,
  input  logic [ADDR_W-1:0] rsp_data,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [ADDR_W-1:0] phys_addr
);
  localparam int FRAME_W = ADDR_W - OFF_W;

  logic [ADDR_W-1:0]  lin_q;
  logic [FRAME_W-1:0] dir_frame_q;
  logic [FRAME_W-1:0] tbl_frame_q;
  logic [IDX_W-1:0]   dir_idx;
  logic [IDX_W-1:0]   tbl_idx;
  logic [ADDR_W-1:0]  dir_entry_addr;
  logic [ADDR_W-1:0]  tbl_entry_addr;

  always_comb begin
    dir_idx        = lin_q[ADDR_W-1 -: IDX_W];
    tbl_idx        = lin_q[OFF_W +: IDX_W];
    dir_entry_addr = {dir_frame_q, {OFF_W{1'b0}}} + (ADDR_W'(dir_idx) << ENTRY_SHIFT);
    tbl_entry_addr = {tbl_frame_q, {OFF_W{1'b0}}} + (ADDR_W'(tbl_idx) << ENTRY_SHIFT);
    mem_req_addr   = (state == WS_PTE) ? tbl_entry_addr : dir_entry_addr;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lin_q       <= '0;
      dir_frame_q <= '0;
      tbl_frame_q <= '0;
      phys_addr   <= '0;
    end else begin
      if (accept) begin
        lin_q       <= lin_in;
        dir_frame_q <= base_in[ADDR_W-1:OFF_W];
      end
      if (take_dir) tbl_frame_q <= rsp_data[ADDR_W-1:OFF_W];
      if (take_pte) phys_addr   <= {rsp_data[ADDR_W-1:OFF_W], lin_q[OFF_W-1:0]};
    end
  end

  p_phys_offset_r3: assert property (@(posedge clk) disable iff (rst)
    take_pte |=> (phys_addr[OFF_W-1:0] == lin_q[OFF_W-1:0]));
  p_entry_aligned_r1: assert property (@(posedge clk) disable iff (rst)
    (state != WS_IDLE) |-> (mem_req_addr[ENTRY_SHIFT-1:0] == '0));
  p_lin_held_r6: assert property (@(posedge clk) disable iff (rst)
    (state == WS_PTE) |=> $stable(lin_q));
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import pt_walker_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int IDX_W       = 10,
  parameter int OFF_W       = 12,
  parameter int PRESENT_BIT = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_lin_addr,
  input  logic [ADDR_W-1:0] dir_base,
  output logic              mem_req_valid,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [ADDR_W-1:0] mem_rsp_data,
  output logic              done,
  output logic              fault,
  output logic [ADDR_W-1:0] phys_addr
);
  localparam int ENTRY_SHIFT = $clog2(ADDR_W / 8);

  logic        accept, take_dir, take_pte;
  walk_state_e state;

  pt_walk_ctrl u_ctrl (
    .clk           (clk),
    .rst           (rst),
    .req_valid     (req_valid),
    .rsp_valid     (mem_rsp_valid),
    .rsp_present   (mem_rsp_data[PRESENT_BIT]),
    .req_ready     (req_ready),
    .accept        (accept),
    .take_dir      (take_dir),
    .take_pte      (take_pte),
    .state         (state),
    .mem_req_valid (mem_req_valid),
    .done          (done),
    .fault         (fault)
  );

  pt_walk_dp #(
    .ADDR_W      (ADDR_W),
    .IDX_W       (IDX_W),
    .OFF_W       (OFF_W),
    .ENTRY_SHIFT (ENTRY_SHIFT)
  ) u_dp (
    .clk          (clk),
    .rst          (rst),
    .accept       (accept),
    .take_dir     (take_dir),
    .take_pte     (take_pte),
    .state        (state),
    .lin_in       (req_lin_addr),
    .base_in      (dir_base),
    .rsp_data     (mem_rsp_data),
    .mem_req_addr (mem_req_addr),
    .phys_addr    (phys_addr)
  );
endmodule

// File: tb/test_pt_walker.sv
module test_pt_walker;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_lin_addr = '0;
  logic [31:0] dir_base = '0;
  logic        mem_req_valid;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic        done, fault;
  logic [31:0] phys_addr;

  int nchk = 0;
  int nerr = 0;

  pt_walker i_pt_walker (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_lin_addr(req_lin_addr), .dir_base(dir_base),
    .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .done(done), .fault(fault), .phys_addr(phys_addr)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // ---------------- memory ----------------
  logic [31:0] mem [logic [31:0]];
  int          lat = 1;
  bit          spur = 1'b0;
  int          cnt = 0;
  int          nreads = 0;
  logic [31:0] pend_addr = '0;

  function automatic logic [31:0] rd(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- cycle reference model ----------------
  int          mph = 0;   // 0 idle,1 dir issue,2 dir wait,3 tbl issue,4 tbl wait,5 done
  logic [31:0] mlin = '0, mbase = '0, mtb = '0, mphys = '0;
  bit          mflt = 1'b0;

  always @(posedge clk) begin
    if (rst) begin
      mph = 0; mflt = 1'b0;
    end else begin
      case (mph)
        0: begin mflt = 1'b0; if (req_valid) begin mlin = req_lin_addr; mbase = dir_base; mph = 1; end end
        1: mph = 2;
        2: if (mem_rsp_valid) begin
             if (!mem_rsp_data[0]) begin mflt = 1'b1; mph = 5; end
             else begin mtb = {mem_rsp_data[31:12], 12'h000}; mph = 3; end
           end
        3: mph = 4;
        4: if (mem_rsp_valid) begin
             mflt  = !mem_rsp_data[0];
             mphys = {mem_rsp_data[31:12], mlin[11:0]};
             mph   = 5;
           end
        default: mph = 0;
      endcase
    end
  end

  // compare every cycle, then run the memory
  always @(negedge clk) begin
    logic [31:0] e_addr;
    e_addr = (mph == 1) ? ({mbase[31:12], 12'h000} + {20'h0, mlin[31:22], 2'b00})
                        : (mtb + {20'h0, mlin[21:12], 2'b00});
    chk("R6 req_ready", {31'h0, req_ready}, {31'h0, mph == 0});
    chk("R7 mem_req_valid", {31'h0, mem_req_valid}, {31'h0, (mph == 1) || (mph == 3)});
    if (mph == 1) chk("R1 directory entry address", mem_req_addr, e_addr);
    if (mph == 3) chk("R2 table entry address", mem_req_addr, e_addr);
    chk("R8 done", {31'h0, done}, {31'h0, mph == 5});
    chk("R4 fault", {31'h0, fault}, {31'h0, (mph == 5) && mflt});
    if (mph == 5 && !mflt) chk("R3 phys_addr", phys_addr, mphys);

    mem_rsp_valid = 1'b0;
    mem_rsp_data  = 32'h0;
    if (rst) cnt = 0;
    else if (cnt > 0) begin
      cnt--;
      if (cnt == 0) begin mem_rsp_valid = 1'b1; mem_rsp_data = rd(pend_addr); end
    end else if (spur) begin
      mem_rsp_valid = 1'b1; mem_rsp_data = 32'hFFFF_FFFF;
    end
    if (mem_req_valid && !rst) begin pend_addr = mem_req_addr; cnt = lat; nreads++; end
  end

  // ---------------- stimulus helpers ----------------
  task automatic map(input logic [31:0] lin, input logic [31:0] base,
                     input logic [19:0] tbl_frame, input logic [11:0] pde_flags,
                     input logic [19:0] pg_frame, input logic [11:0] pte_flags);
    mem[{base[31:12], 12'h000} + 32'(lin[31:22]) * 4] = {tbl_frame, pde_flags};
    mem[{tbl_frame, 12'h000} + 32'(lin[21:12]) * 4]   = {pg_frame, pte_flags};
  endtask

  task automatic expect_walk(input logic [31:0] lin, input logic [31:0] base,
                             output logic [31:0] ph, output bit f, output int n);
    logic [31:0] pde, pte;
    pde = rd({base[31:12], 12'h000} + 32'(lin[31:22]) * 4);
    if (!pde[0]) begin f = 1'b1; n = 1; ph = '0; return; end
    pte = rd({pde[31:12], 12'h000} + 32'(lin[21:12]) * 4);
    n = 2; f = !pte[0]; ph = {pte[31:12], lin[11:0]};
  endtask

  task automatic wait_done(output bit seen);
    seen = 1'b0;
    for (int i = 0; i < 60; i++) begin
      if (done) begin seen = 1'b1; break; end
      @(negedge clk);
    end
  endtask

  task automatic walk(input logic [31:0] lin, input logic [31:0] base,
                      input int l, input bit sp, input bit hold, input string tag);
    logic [31:0] eph; bit ef; int en; bit seen;
    expect_walk(lin, base, eph, ef, en);
    lat = l; spur = sp;
    @(negedge clk);
    nreads = 0;
    req_valid = 1'b1; req_lin_addr = lin; dir_base = base;
    @(negedge clk);
    req_valid = hold;
    req_lin_addr = $urandom; dir_base = $urandom;   // R6: fields change while busy
    wait_done(seen);
    req_valid = 1'b0;
    chk({tag, " R8 done seen"}, {31'h0, seen}, 32'h1);
    if (ef) chk({tag, " R5 fault result"}, {31'h0, fault}, 32'h1);
    else begin
      chk({tag, " R3 translated address"}, phys_addr, eph);
      chk({tag, " R3 no fault"}, {31'h0, fault}, 32'h0);
    end
    chk({tag, " R4 read count"}, nreads, en);
    spur = 1'b0;
  endtask

  // ---------------- test sequence ----------------
  initial begin
    bit seen;
    repeat (3) @(negedge clk);
    chk("R9 reset req_ready", {31'h0, req_ready}, 32'h1);
    chk("R9 reset done", {31'h0, done}, 32'h0);
    chk("R9 reset fault", {31'h0, fault}, 32'h0);
    chk("R9 reset mem_req_valid", {31'h0, mem_req_valid}, 32'h0);
    rst = 1'b0;

    map(32'h1234_5678, 32'h0001_0000, 20'h00200, 12'h003, 20'hABCDE, 12'h001);
    walk(32'h1234_5678, 32'h0001_0000, 1, 1'b0, 1'b0, "basic R1 R2");

    map(32'h0000_0ABC, 32'h0001_0000, 20'h00300, 12'h001, 20'h11111, 12'h001);
    walk(32'h0000_0ABC, 32'h0001_0000, 4, 1'b1, 1'b0, "zero index R7");

    map(32'hFFFF_FFFF, 32'h0040_0FFF, 20'h00500, 12'hFFF, 20'hFEDCB, 12'hFFF);
    walk(32'hFFFF_FFFF, 32'h0040_0FFF, 2, 1'b1, 1'b0, "top index R10");

    mem[32'h0001_0000 + 32'h3FE * 4] = 32'h0060_0FFE;
    walk(32'hFF80_0123, 32'h0001_0000, 2, 1'b0, 1'b0, "dir fault R4");

    map(32'h0841_2345, 32'h0001_0000, 20'h00700, 12'h001, 20'h22222, 12'hFFE);
    walk(32'h0841_2345, 32'h0001_0000, 3, 1'b1, 1'b0, "table fault R5");

    map(32'h4000_1234, 32'h0001_0000, 20'h00800, 12'h001, 20'h33333, 12'h001);
    walk(32'h4000_1234, 32'h0001_0000, 1, 1'b0, 1'b1, "held request R6");

    // R9: reset in the middle of a walk
    lat = 4;
    @(negedge clk);
    req_valid = 1'b1; req_lin_addr = 32'h1234_5678; dir_base = 32'h0001_0000;
    @(negedge clk); req_valid = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    chk("R9 mid-walk reset ready", {31'h0, req_ready}, 32'h1);
    chk("R9 mid-walk reset done", {31'h0, done}, 32'h0);
    rst = 1'b0;
    repeat (6) @(negedge clk);
    chk("R9 no late done", {31'h0, done}, 32'h0);
    walk(32'h1234_5678, 32'h0001_0000, 1, 1'b1, 1'b0, "after reset R9");

    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nerr++;
    $display("FAIL R8 watchdog: run did not complete");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule